// File: doc/BRIEF.md
# Banked Interrupt Status and Enable Registers

This block is the interrupt front end of a small Ethernet-style controller, seen by a host through a 16-bit register window. One register, readable and writable at the same offset in every bank, chooses the bank that the other offsets reach. Interrupt registers are reachable only when that bank value is 18. The bank value persists until the host rewrites it. Interrupt handlers can therefore read it on entry, work in bank 18, and write the saved value back on exit.

Seven single-cycle event inputs set sticky status bits. The host clears status bits by writing ones to them. A separate enable register masks which status bits drive the single interrupt output, and that output is registered. The host writes the value 1 to a 32-bit acknowledge word, which sits outside the banks, to make the output drop for one cycle. This gives an edge to an edge-sensitive interrupt receiver while a source stays pending.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset, the bank value, the status bits, the enable bits, the interrupt output and the read data are all zero.
- R2: A write to offset 0x0E stores host_wdata[15:0] as the bank value, whatever the current bank. A read of 0x0E returns the bank value in any bank. No access to any other offset changes the bank value.
- R3: With the bank value at 18, offset 0x02 reads the status register. A pulse on evt_in sets the matching status bit at the same clock edge. The mapping is evt_in[6] to bit 15 (link change), [5] to bit 14 (transmit done), [4] to bit 13 (frame received), [3] to bit 11 (receive overrun), [2] to bit 9 (transmitter halted), [1] to bit 8 (receiver halted) and [0] to bit 7 (receive error). A status bit stays set until it is cleared.
- R4: A write to status (bank 18, offset 0x02) clears each bit whose written bit is 1 and leaves the others unchanged. Writing 0xFFFF clears every bit, and writing 0x0000 changes nothing.
- R5: If an event pulse and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R6: irq_out is 1 exactly when, at the previous edge, (status AND enable) was nonzero and no acknowledge was written. It changes one cycle after the status or enable register changes.
- R7: Writing 0x0000 to the enable register (bank 18, offset 0x00) brings irq_out low while status bits stay set. Re-enabling a pending bit brings irq_out back high one cycle after the write.
- R8: A write of the 32-bit value 0x00000001 to offset 0x2C, in any bank, forces irq_out low for the following cycle only. Any other value written there has no effect.
- R9: A read returns zero in these cases: offsets other than 0x0E, 0x00 and 0x02; offsets 0x00 and 0x02 outside bank 18; offset 0x2C. Bits 31:16 always read zero. Status and enable bits outside the seven mapped positions (mask 0xEB80) read zero and cannot be set.
- R10: Writes to offsets 0x00 and 0x02 have no effect unless the bank value is 18.
- R11: host_rdata shows the value addressed by a read strobe from the clock edge that samples the strobe onward, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 6 | Byte offset of the access |
| host_wdata | input | 32 | Write data; banked registers use bits 15:0 |
| host_rdata | output | 32 | Registered read data |
| evt_in | input | 7 | Single-cycle event pulses, mapping in R3 |
| irq_out | output | 1 | Registered interrupt request |

## Verification
An event sampled at edge E is readable on a read strobe issued in the following cycle, and it raises irq_out after edge E+1. An enable write or a status clear at edge W moves irq_out after edge W+1. An acknowledge at edge A pulls irq_out low right after A, and the output recovers after A+1. Read data for a strobe sampled at edge R is valid from just after R. The bench drives every input at the falling edge and samples at the next falling edge. For each read, a driver pushes the expected word into a queue; a monitor pops that word on the falling edge after the sampling edge. Interrupt checks wait the exact number of falling edges listed above, so that a one-cycle-late or one-cycle-early output is reported.

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] IRQ_BANK = 16'd18,
  parameter logic [ADDR_W-1:0] OFS_BANK = 6'h0E,
  parameter logic [ADDR_W-1:0] OFS_EN = 6'h00,
  parameter logic [ADDR_W-1:0] OFS_ST = 6'h02,
  parameter logic [ADDR_W-1:0] OFS_ACK = 6'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [6:0]        evt_in,
  output logic              irq_out
);
  localparam int N_EVT = 7;
  localparam int EVT_POS [N_EVT] = '{15, 14, 13, 11, 9, 8, 7};

  function automatic logic [REG_W-1:0] spread(input logic [N_EVT-1:0] e);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_EVT; i++) r[EVT_POS[i]] = e[N_EVT-1-i];
    return r;
  endfunction

  localparam logic [REG_W-1:0] LIVE = spread('1);

  logic [REG_W-1:0]  bank_q, en_q, st_q;
  logic [REG_W-1:0]  rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  wire in_irq_bank = (bank_q == IRQ_BANK);
  wire wr_bank = host_wr && (host_addr == OFS_BANK);
  wire wr_en   = host_wr && in_irq_bank && (host_addr == OFS_EN);
  wire wr_st   = host_wr && in_irq_bank && (host_addr == OFS_ST);
  wire ack     = host_wr && (host_addr == OFS_ACK) && (host_wdata == DATA_W'(1));

  wire [REG_W-1:0] clr_bits = wr_st ? host_wdata[REG_W-1:0] : '0;
  wire [REG_W-1:0] st_next  = (st_q & ~clr_bits) | spread(evt_in);

  always_comb begin
    rd_word = '0;
    if (host_addr == OFS_BANK) rd_word = bank_q;
    else if (in_irq_bank && host_addr == OFS_EN) rd_word = en_q;
    else if (in_irq_bank && host_addr == OFS_ST) rd_word = st_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= '0;
      en_q    <= '0;
      st_q    <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_bank) bank_q <= host_wdata[REG_W-1:0];
      if (wr_en) en_q <= host_wdata[REG_W-1:0] & LIVE;
      st_q  <= st_next;
      irq_q <= (|(st_q & en_q)) && !ack;
      if (host_rd) rdata_q <= {{(DATA_W-REG_W){1'b0}}, rd_word};
    end
  end

  assign host_rdata = rdata_q;
  assign irq_out    = irq_q;
endmodule

// File: rtl/bank_irq_chk.sv
module bank_irq_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] IRQ_BANK = 16'd18,
  parameter logic [ADDR_W-1:0] OFS_BANK = 6'h0E,
  parameter logic [ADDR_W-1:0] OFS_ST = 6'h02,
  parameter logic [ADDR_W-1:0] OFS_ACK = 6'h2C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [6:0]        evt_in,
  input logic              irq_out,
  input logic [REG_W-1:0]  bank_q,
  input logic [REG_W-1:0]  en_q,
  input logic [REG_W-1:0]  st_q
);
  localparam logic [REG_W-1:0] MAPPED = 16'hEB80;

  logic [REG_W-1:0] evt_bits;
  always_comb
    evt_bits = {evt_in[6], evt_in[5], evt_in[4], 1'b0, evt_in[3], 1'b0,
                evt_in[2], evt_in[1], evt_in[0], 7'b0};

  wire st_write  = host_wr && bank_q == IRQ_BANK && host_addr == OFS_ST;
  wire ack_write = host_wr && host_addr == OFS_ACK && host_wdata == DATA_W'(1);

  a_r2_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == OFS_BANK) |=> $stable(bank_q));

  a_r5_event_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((st_q & $past(evt_bits)) == $past(evt_bits)));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (st_write && evt_in == '0) |=> ((st_q & $past(host_wdata[REG_W-1:0])) == '0));

  a_r6_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(st_q & en_q)) && !ack_write) |=> irq_out);

  a_r6_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_q & en_q)) |=> !irq_out);

  a_r7_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_out);

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_write |=> !irq_out);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q) & ~MAPPED) == '0);
endmodule

bind bank_irq_ctrl bank_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .IRQ_BANK(IRQ_BANK),
  .OFS_BANK(OFS_BANK), .OFS_ST(OFS_ST), .OFS_ACK(OFS_ACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .evt_in(evt_in), .irq_out(irq_out),
  .bank_q(bank_q), .en_q(en_q), .st_q(st_q)
);

// File: tb/tb_bank_irq_ctrl.sv
module tb_bank_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [6:0]  evt_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bank_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_in(evt_in), .irq_out(irq_out)
  );

  always @(posedge clk) rd_seen <= host_rd;

  logic [31:0] m_exp;
  string       m_tag;
  always @(negedge clk) begin
    if (rd_seen) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 read with no expected item, got %h", host_rdata);
      end else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        if (host_rdata !== m_exp) begin
          bad++;
          $display("FAIL %s read got %h expected %h", m_tag, host_rdata, m_exp);
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic wr_evt(input logic [5:0] a, input logic [31:0] d, input logic [6:0] e);
    host_wr = 1'b1; host_addr = a; host_wdata = d; evt_in = e;
    tick();
    host_wr = 1'b0; evt_in = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    host_rd = 1'b1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    tick();
    host_rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_in = e;
    tick();
    evt_in = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  function automatic logic [31:0] evt_pos(input int j);
    case (j)
      6: return 32'h8000;
      5: return 32'h4000;
      4: return 32'h2000;
      3: return 32'h0800;
      2: return 32'h0200;
      1: return 32'h0100;
      default: return 32'h0080;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    chk_irq(1'b0, "R1");
    rd(6'h0E, 32'h0, "R1 bank");
    rd(6'h02, 32'h0, "R9 status outside bank");
    wr(6'h0E, 32'd18);
    rd(6'h0E, 32'd18, "R2 bank readback");
    rd(6'h02, 32'h0, "R1 status");
    rd(6'h00, 32'h0, "R1 enable");

    for (int j = 0; j < 7; j++) begin
      pulse(7'(1 << j));
      rd(6'h02, evt_pos(j), "R3 single event");
      tick();
      chk_irq(1'b0, "R7 disabled event");
      wr(6'h02, evt_pos(j));
      rd(6'h02, 32'h0, "R4 clear one");
    end
    pulse(7'h7F);
    rd(6'h02, 32'h0000EB80, "R3 all events");
    wr(6'h02, 32'h0000FFFF);
    rd(6'h02, 32'h0, "R4 clear all");

    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0000EB80, "R9 enable mask");
    pulse(7'b0010000);
    chk_irq(1'b0, "R6 not yet");
    tick();
    chk_irq(1'b1, "R6 raised");
    wr(6'h00, 32'h0);
    chk_irq(1'b1, "R6 enable latency");
    tick();
    chk_irq(1'b0, "R7 disabled");
    rd(6'h02, 32'h00002000, "R7 status kept");
    wr(6'h00, 32'h00002000);
    tick();
    chk_irq(1'b1, "R7 reenabled");

    wr(6'h2C, 32'h1);
    chk_irq(1'b0, "R8 ack drop");
    tick();
    chk_irq(1'b1, "R8 ack recover");
    wr(6'h2C, 32'h2);
    chk_irq(1'b1, "R8 other value");
    wr(6'h2C, 32'h0001_0001);
    chk_irq(1'b1, "R8 upper bits");

    wr_evt(6'h02, 32'h00008000, 7'b1000000);
    rd(6'h02, 32'h0000A000, "R5 event wins");
    wr(6'h02, 32'h0);
    rd(6'h02, 32'h0000A000, "R4 zero write");
    wr(6'h02, 32'h0000FFFF);
    tick();
    chk_irq(1'b0, "R4 cleared irq");

    wr(6'h00, 32'h0000EB80);
    pulse(7'b0100000);
    tick();
    chk_irq(1'b1, "R10 pending");
    wr(6'h0E, 32'd3);
    wr(6'h02, 32'h0000FFFF);
    wr(6'h00, 32'h0);
    rd(6'h02, 32'h0, "R9 other bank");
    rd(6'h0E, 32'd3, "R2 saved bank");
    tick();
    chk_irq(1'b1, "R10 writes ignored");
    wr(6'h2C, 32'h1);
    chk_irq(1'b0, "R8 ack any bank");
    wr(6'h0E, 32'd18);
    rd(6'h02, 32'h00004000, "R10 status intact");
    rd(6'h00, 32'h0000EB80, "R10 enable intact");
    rd(6'h04, 32'h0, "R9 undefined offset");
    rd(6'h2C, 32'h0, "R9 ack reads zero");
    rd(6'h0E, 32'd18, "R11 back to back");
    rd(6'h02, 32'h00004000, "R11 second read");
    tick();
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule